// File: doc/BRIEF.md
# Two-Wire Pointer-Addressed Register Slave

This block is the bus side of a temperature sensing function. It listens to a two-wire serial bus, sampled by a fast system clock. It answers a 7-bit address made of a fixed 4-bit prefix followed by three bits taken from input pins. Through an 8-bit pointer it gives the host access to four registers. The first is a temperature value supplied by the sensor path, which the host can only read. The second is a 7-bit control register, which reads as a byte. The other two are a lower setpoint and an upper setpoint, each 16 bits wide.

The host selects a register by writing a pointer byte. That pointer is kept after STOP, so later reads of the same register can skip the pointer write. Data moves most significant bit first, and 16-bit registers move high byte first. The block drives the control fields and both setpoints straight to the alarm logic. It also gives that logic two one-cycle pulses: one when a register read completes, and one when shutdown is switched on.

Top module: `tsense_i2c_regs`

## Requirements
- R1: The block acknowledges an address byte only when it equals {4'b1001, addr_pins[2:0], rw}, with rw=1 meaning read. On a mismatch it leaves SDA released until the next START.
- R2: SDA falling while SCL is high is a START. SDA rising while SCL is high is a STOP. A START in the middle of a transaction, with no STOP before it, begins a new address phase.
- R3: In a write transaction, the first byte after the address is loaded into the pointer. The pointer resets to 00h and is kept across transactions.
- R4: The pointer selects 00h temperature, 01h control, 02h lower setpoint and 03h upper setpoint. Pointer values above 03h use only their low two bits.
- R5: The control byte holds, from bit 6 down to bit 0: resolution (2 bits), fault count (2 bits), alarm polarity, alarm mode and shutdown. It resets to 00h. The lower setpoint resets to 4B00h and the upper setpoint to 5000h.
- R6: A write to control bit 7 is accepted, but that bit always reads back as 0.
- R7: A 16-bit register is written high byte first, then low byte. It changes only once its low byte arrives. Writes to the temperature register have no effect.
- R8: Every byte the block receives after a matching address is acknowledged by SDA held low through the ninth clock. The block changes SDA only while SCL is low.
- R9: In a read, a master ACK continues the transfer. A 16-bit register wraps to its high byte again, and the control byte repeats. A master NACK makes the block release SDA and send nothing more.
- R10: A 16-bit value is captured when its read starts. A change at the temperature input partway through the read does not alter the bytes already being sent.
- R11: `read_pulse` is high for exactly one cycle each time the last byte of a register has been sent.
- R12: `shutdown_pulse` is high for one cycle only when a control write changes the shutdown bit from 0 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock level |
| sda_in | input | 1 | Bus data level |
| addr_pins | input | 3 | Low three bits of the slave address |
| temp_in | input | 16 | Current temperature word, two's complement |
| sda_drive_low | output | 1 | High to pull SDA low |
| res_sel | output | 2 | Resolution field of the control register |
| fault_sel | output | 2 | Fault count field of the control register |
| alarm_pol | output | 1 | Alarm polarity bit |
| alarm_mode | output | 1 | Alarm mode bit |
| shutdown | output | 1 | Shutdown bit |
| hyst_setpoint | output | 16 | Lower setpoint |
| high_setpoint | output | 16 | Upper setpoint |
| read_pulse | output | 1 | One-cycle pulse when a register read completes |
| shutdown_pulse | output | 1 | One-cycle pulse when shutdown is switched on |

## Verification
The bench sweeps the three pin-set address bits and two wrong prefixes. A faulty matcher would either acknowledge a neighbouring address or accept a write meant for another device, and that stray write would then show up as a moved pointer. It sends a single high byte with no low byte after it. A design that committed bytes one at a time would leave a half-updated setpoint. The bench changes the temperature input between the two bytes of a read, which catches a design that reads the live value instead of a captured copy. It also reads with ACK past the end of a register, checks the wrap, and checks that SDA is released after NACK. A repeated START and a pointer above 03h cover the restart and aliasing rules. Shutdown written as 1 twice, and as 1 after 0, shows a pulse fired on a level instead of an edge.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_RX_ACK,
    PH_TX,
    PH_TX_ACK
  } phase_t;

  localparam logic [1:0] SEL_TEMP = 2'd0;
  localparam logic [1:0] SEL_CTRL = 2'd1;
  localparam logic [1:0] SEL_LOW  = 2'd2;
  localparam logic [1:0] SEL_HIGH = 2'd3;

  function automatic logic sel_is_wide(input logic [1:0] sel);
    return sel != SEL_CTRL;
  endfunction
endpackage

// File: rtl/tsr_sync.sv
module tsr_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/tsr_bus_events.sv
module tsr_bus_events #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [1:0] synced;
  logic       scl_prev, sda_prev;

  tsr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({scl_raw, sda_raw}), .q(synced)
  );

  assign scl_lvl = synced[1];
  assign sda_lvl = synced[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_lvl;
      sda_prev <= sda_lvl;
    end
  end

  assign scl_rise = scl_lvl & ~scl_prev;
  assign scl_fall = ~scl_lvl & scl_prev;
  assign start_ev = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_ev  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/tsr_regfile.sv
module tsr_regfile
  import tsr_pkg::*;
#(
  parameter int              DATA_W   = 16,
  parameter logic [DATA_W-1:0] LOW_RST  = 16'h4B00,
  parameter logic [DATA_W-1:0] HIGH_RST = 16'h5000,
  localparam int             BYTE_W   = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              wr_second,
  input  logic [DATA_W-1:0] temp_in,
  output logic [DATA_W-1:0] rd_word,
  output logic [6:0]        ctrl,
  output logic [DATA_W-1:0] low_sp,
  output logic [DATA_W-1:0] high_sp,
  output logic              sd_pulse
);
  logic [BYTE_W-1:0] pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= '0;
      low_sp   <= LOW_RST;
      high_sp  <= HIGH_RST;
      pend     <= '0;
      sd_pulse <= 1'b0;
    end else begin
      sd_pulse <= 1'b0;
      if (wr_en) begin
        case (sel)
          SEL_CTRL: begin
            ctrl     <= wr_data[6:0];
            sd_pulse <= wr_data[0] & ~ctrl[0];
          end
          SEL_LOW, SEL_HIGH: begin
            if (!wr_second) pend <= wr_data;
            else if (sel == SEL_LOW) low_sp <= {pend, wr_data};
            else high_sp <= {pend, wr_data};
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (sel)
      SEL_TEMP: rd_word = temp_in;
      SEL_CTRL: rd_word = {1'b0, ctrl, {BYTE_W{1'b0}}};
      SEL_LOW:  rd_word = low_sp;
      default:  rd_word = high_sp;
    endcase
  end
endmodule

// File: rtl/tsense_i2c_regs.sv
module tsense_i2c_regs
  import tsr_pkg::*;
#(
  parameter int         PTR_W       = 8,
  parameter int         DATA_W      = 16,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_PREFIX  = 4'b1001,
  localparam int        BYTE_W      = DATA_W / 2,
  localparam int        BIT_W       = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [2:0]        addr_pins,
  input  logic [DATA_W-1:0] temp_in,
  output logic              sda_drive_low,
  output logic [1:0]        res_sel,
  output logic [1:0]        fault_sel,
  output logic              alarm_pol,
  output logic              alarm_mode,
  output logic              shutdown,
  output logic [DATA_W-1:0] hyst_setpoint,
  output logic [DATA_W-1:0] high_setpoint,
  output logic              read_pulse,
  output logic              shutdown_pulse
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  phase_t            phase_q;
  logic [BIT_W-1:0]  bit_q;
  logic [BYTE_W-1:0] sh_q, tx_q, wr_data_q;
  logic [PTR_W-1:0]  ptr_q;
  logic [DATA_W-1:0] shadow_q, rd_word;
  logic [6:0]        ctrl;
  logic full_q, addr_ph_q, rw_q, first_q, wide_q, low_q, mack_q;
  logic wr_en_q, wr_second_q, wr_half_q, drive_q, rd_pulse_q;
  logic addr_hit;

  tsr_bus_events #(.SYNC_STAGES(SYNC_STAGES)) u_events (
    .clk(clk), .rst(rst), .scl_raw(scl_in), .sda_raw(sda_in),
    .scl_lvl(scl_s), .sda_lvl(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
  );

  tsr_regfile #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en_q), .sel(ptr_q[1:0]),
    .wr_data(wr_data_q), .wr_second(wr_second_q), .temp_in(temp_in),
    .rd_word(rd_word), .ctrl(ctrl), .low_sp(hyst_setpoint),
    .high_sp(high_setpoint), .sd_pulse(shutdown_pulse)
  );

  assign addr_hit = sh_q[BYTE_W-1:1] == {DEV_PREFIX, addr_pins};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;  bit_q <= '0;  sh_q <= '0;  tx_q <= '0;
      ptr_q <= '0;  shadow_q <= '0;  wr_data_q <= '0;
      full_q <= 1'b0;  addr_ph_q <= 1'b0;  rw_q <= 1'b0;  first_q <= 1'b0;
      wide_q <= 1'b0;  low_q <= 1'b0;  mack_q <= 1'b0;  wr_en_q <= 1'b0;
      wr_second_q <= 1'b0;  wr_half_q <= 1'b0;  drive_q <= 1'b0;
      rd_pulse_q <= 1'b0;
    end else begin
      rd_pulse_q <= 1'b0;
      wr_en_q    <= 1'b0;
      if (start_ev) begin
        phase_q <= PH_RX;  addr_ph_q <= 1'b1;  bit_q <= '0;
        full_q <= 1'b0;  drive_q <= 1'b0;
      end else if (stop_ev) begin
        phase_q <= PH_IDLE;  full_q <= 1'b0;  drive_q <= 1'b0;
      end else begin
        case (phase_q)
          PH_RX: begin
            if (scl_rise) begin
              sh_q   <= {sh_q[BYTE_W-2:0], sda_s};
              bit_q  <= bit_q + 1'b1;
              full_q <= bit_q == LAST_BIT;
            end else if (scl_fall && full_q) begin
              full_q <= 1'b0;
              if (addr_ph_q) begin
                addr_ph_q <= 1'b0;
                if (addr_hit) begin
                  rw_q     <= sh_q[0];
                  first_q  <= ~sh_q[0];
                  shadow_q <= rd_word;
                  wide_q   <= sel_is_wide(ptr_q[1:0]);
                  drive_q  <= 1'b1;
                  phase_q  <= PH_RX_ACK;
                end else begin
                  phase_q <= PH_IDLE;
                end
              end else begin
                drive_q <= 1'b1;
                phase_q <= PH_RX_ACK;
                if (first_q) begin
                  ptr_q     <= sh_q;
                  first_q   <= 1'b0;
                  wr_half_q <= 1'b0;
                end else begin
                  wr_en_q     <= 1'b1;
                  wr_data_q   <= sh_q;
                  wr_second_q <= wr_half_q;
                  wr_half_q   <= ~wr_half_q;
                end
              end
            end
          end
          PH_RX_ACK: begin
            if (scl_fall) begin
              bit_q <= '0;
              if (rw_q) begin
                phase_q <= PH_TX;
                tx_q    <= shadow_q[DATA_W-1:BYTE_W];
                drive_q <= ~shadow_q[DATA_W-1];
                low_q   <= 1'b0;
              end else begin
                phase_q <= PH_RX;
                drive_q <= 1'b0;
              end
            end
          end
          PH_TX: begin
            if (scl_fall) begin
              if (bit_q == LAST_BIT) begin
                phase_q <= PH_TX_ACK;
                drive_q <= 1'b0;
              end else begin
                tx_q    <= tx_q << 1;
                drive_q <= ~tx_q[BYTE_W-2];
                bit_q   <= bit_q + 1'b1;
              end
            end
          end
          PH_TX_ACK: begin
            if (scl_rise) begin
              mack_q     <= ~sda_s;
              rd_pulse_q <= ~wide_q | low_q;
            end else if (scl_fall) begin
              bit_q <= '0;
              if (mack_q) begin
                phase_q <= PH_TX;
                if (wide_q && !low_q) begin
                  tx_q    <= shadow_q[BYTE_W-1:0];
                  drive_q <= ~shadow_q[BYTE_W-1];
                  low_q   <= 1'b1;
                end else begin
                  shadow_q <= rd_word;
                  wide_q   <= sel_is_wide(ptr_q[1:0]);
                  tx_q     <= rd_word[DATA_W-1:BYTE_W];
                  drive_q  <= ~rd_word[DATA_W-1];
                  low_q    <= 1'b0;
                end
              end else begin
                phase_q <= PH_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_drive_low = drive_q;
  assign read_pulse    = rd_pulse_q;
  assign res_sel       = ctrl[6:5];
  assign fault_sel     = ctrl[4:3];
  assign alarm_pol     = ctrl[2];
  assign alarm_mode    = ctrl[1];
  assign shutdown      = ctrl[0];
endmodule

// File: rtl/tsr_checker.sv
module tsr_checker #(
  parameter int PTR_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             scl_lvl,
  input logic             scl_fall_ev,
  input logic             stop_ev,
  input logic             sda_drive_low,
  input logic             read_pulse,
  input logic             shutdown_pulse,
  input logic             shutdown,
  input logic [PTR_W-1:0] ptr
);
  a_r8_drive_while_scl_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_drive_low) |-> !$past(scl_lvl));

  a_r2_stop_releases: assert property (@(posedge clk) disable iff (rst)
    stop_ev |=> !sda_drive_low);

  a_r11_read_pulse_single: assert property (@(posedge clk) disable iff (rst)
    read_pulse |=> !read_pulse);

  a_r12_sd_rising_only: assert property (@(posedge clk) disable iff (rst)
    shutdown_pulse |-> (shutdown && !$past(shutdown)));

  a_r3_ptr_moves_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(ptr) |-> $past(scl_fall_ev));
endmodule

bind tsense_i2c_regs tsr_checker #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst(rst), .scl_lvl(scl_s), .scl_fall_ev(scl_fall),
  .stop_ev(stop_ev), .sda_drive_low(sda_drive_low), .read_pulse(read_pulse),
  .shutdown_pulse(shutdown_pulse), .shutdown(shutdown), .ptr(ptr_q)
);

// File: tb/test_tsense_i2c_regs.sv
module test_tsense_i2c_regs;
  localparam int H = 6;
  localparam logic [2:0] PINS = 3'b101;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [15:0] temp_in = 16'h1910;
  logic sda_drive_low, alarm_pol, alarm_mode, shutdown, read_pulse, shutdown_pulse;
  logic [1:0] res_sel, fault_sel;
  logic [15:0] hyst_setpoint, high_setpoint;
  logic sda_bus;
  int n_cmp = 0, n_bad = 0, rd_cnt = 0, sd_cnt = 0;

  always #5 clk = ~clk;
  assign sda_bus = m_sda & ~sda_drive_low;

  tsense_i2c_regs i_tsense_i2c_regs (
    .clk(clk), .rst(rst), .scl_in(m_scl), .sda_in(sda_bus), .addr_pins(PINS),
    .temp_in(temp_in), .sda_drive_low(sda_drive_low), .res_sel(res_sel),
    .fault_sel(fault_sel), .alarm_pol(alarm_pol), .alarm_mode(alarm_mode),
    .shutdown(shutdown), .hyst_setpoint(hyst_setpoint), .high_setpoint(high_setpoint),
    .read_pulse(read_pulse), .shutdown_pulse(shutdown_pulse)
  );

  always @(posedge clk) begin
    if (read_pulse) rd_cnt++;
    if (shutdown_pulse) sd_cnt++;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_start;
    m_sda = 1'b1; idle(H); m_scl = 1'b1; idle(H);
    m_sda = 1'b0; idle(H); m_scl = 1'b0; idle(2);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; idle(H); m_scl = 1'b1; idle(H); m_sda = 1'b1; idle(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; idle(H); m_scl = 1'b1; idle(H); m_scl = 1'b0; idle(2);
    end
    m_sda = 1'b1; idle(H); m_scl = 1'b1; idle(H / 2);
    ack = ~sda_bus;
    idle(H / 2); m_scl = 1'b0; idle(2);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      idle(H); m_scl = 1'b1; idle(H / 2); b[i] = sda_bus;
      idle(H / 2); m_scl = 1'b0; idle(2);
    end
    m_sda = ~give_ack; idle(H); m_scl = 1'b1; idle(H); m_scl = 1'b0; idle(2);
    m_sda = 1'b1;
  endtask

  task automatic wr_bytes(input logic [7:0] p, input int n, input logic [15:0] d);
    logic a;
    bus_start;
    send_byte({4'b1001, PINS, 1'b0}, a); chk("R1 addr ack", 16'(a), 16'd1);
    send_byte(p, a); chk("R8 pointer ack", 16'(a), 16'd1);
    if (n == 1) begin send_byte(d[7:0], a); chk("R8 data ack", 16'(a), 16'd1); end
    if (n == 2) begin
      send_byte(d[15:8], a); chk("R8 data ack", 16'(a), 16'd1);
      send_byte(d[7:0], a);  chk("R8 data ack", 16'(a), 16'd1);
    end
    bus_stop;
  endtask

  task automatic rd_word16(output logic [15:0] w);
    logic a; logic [7:0] hi, lo;
    bus_start;
    send_byte({4'b1001, PINS, 1'b1}, a); chk("R1 read addr ack", 16'(a), 16'd1);
    recv_byte(1'b1, hi); recv_byte(1'b0, lo);
    bus_stop;
    w = {hi, lo};
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic a; logic [7:0] b0, b1, b2, b3; logic [15:0] w; int c0;
    idle(4); rst = 1'b0; idle(4);
    // R5 reset values
    chk("R5 reset ctrl", {9'd0, res_sel, fault_sel, alarm_pol, alarm_mode, shutdown}, 16'h0);
    chk("R5 reset low sp", hyst_setpoint, 16'h4B00);
    chk("R5 reset high sp", high_setpoint, 16'h5000);
    chk("R8 reset released", 16'(sda_drive_low), 16'd0);

    // R1 address sweep over pin bits and wrong prefixes
    for (int k = 0; k < 10; k++) begin
      logic [7:0] ad;
      ad = (k < 8) ? {4'b1001, 3'(k), 1'b0} : (k == 8 ? {4'b1000, PINS, 1'b0} : {4'b1101, PINS, 1'b0});
      bus_start; send_byte(ad, a);
      chk("R1 address match", 16'(a), 16'((k < 8) && (3'(k) == PINS)));
      if (!a) begin send_byte(8'h01, a); chk("R1 ignored after mismatch", 16'(a), 16'd0); end
      bus_stop;
    end

    // R3 pointer reset value 00h (temperature), R4 map
    rd_word16(w); chk("R3 pointer reset to temp", w, 16'h1910);

    // R4 temperature sweep, pointer persists (R3)
    for (int i = 0; i < 12; i++) begin
      temp_in = 16'(i * 16'h1357 + 16'h0A20);
      rd_word16(w); chk("R4 temp readback", w, 16'(i * 16'h1357 + 16'h0A20));
    end

    // R7 write to temperature ignored
    temp_in = 16'hE6F0;
    wr_bytes(8'h00, 2, 16'hAAAA);
    rd_word16(w); chk("R7 temp write ignored", w, 16'hE6F0);

    // R5 R6 R12 control register
    c0 = sd_cnt;
    wr_bytes(8'h01, 1, 16'h00FF);
    chk("R5 ctrl fields", {9'd0, res_sel, fault_sel, alarm_pol, alarm_mode, shutdown}, 16'h007F);
    chk("R12 sd pulse on set", 16'(sd_cnt - c0), 16'd1);
    wr_bytes(8'h01, 1, 16'h0001);
    chk("R12 no pulse when already set", 16'(sd_cnt - c0), 16'd1);
    wr_bytes(8'h01, 1, 16'h0000);
    wr_bytes(8'h01, 1, 16'h00C9);
    chk("R12 pulse after clear", 16'(sd_cnt - c0), 16'd2);
    chk("R5 ctrl fields 2", {9'd0, res_sel, fault_sel, alarm_pol, alarm_mode, shutdown}, 16'h0049);

    // R6 R9 R11 read control with continued ACK
    c0 = rd_cnt;
    bus_start; send_byte({4'b1001, PINS, 1'b1}, a);
    recv_byte(1'b1, b0); recv_byte(1'b1, b1); recv_byte(1'b0, b2);
    idle(2); chk("R9 released after nack", 16'(sda_drive_low), 16'd0);
    bus_stop;
    chk("R6 reserved bit reads 0", 16'(b0), 16'h49);
    chk("R9 ctrl repeats", {b1, b2}, 16'h4949);
    chk("R11 one pulse per ctrl byte", 16'(rd_cnt - c0), 16'd3);

    // R7 half write leaves setpoint unchanged, full write commits
    wr_bytes(8'h03, 1, 16'h0012);
    chk("R7 high byte alone no commit", high_setpoint, 16'h5000);
    wr_bytes(8'h03, 2, 16'hABCD);
    chk("R7 upper setpoint written", high_setpoint, 16'hABCD);
    wr_bytes(8'hFE, 2, 16'h1234);
    chk("R4 pointer alias low sp", hyst_setpoint, 16'h1234);
    rd_word16(w); chk("R4 alias readback", w, 16'h1234);

    // R2 repeated start: set pointer then read without STOP
    bus_start; send_byte({4'b1001, PINS, 1'b0}, a); send_byte(8'h03, a);
    c0 = rd_cnt;
    bus_start; send_byte({4'b1001, PINS, 1'b1}, a);
    chk("R2 ack after repeated start", 16'(a), 16'd1);
    recv_byte(1'b1, b0); recv_byte(1'b1, b1); recv_byte(1'b1, b2); recv_byte(1'b0, b3);
    bus_stop;
    chk("R2 upper sp via restart", {b0, b1}, 16'hABCD);
    chk("R9 16-bit wraps", {b2, b3}, 16'hABCD);
    chk("R11 one pulse per register", 16'(rd_cnt - c0), 16'd2);

    // R10 capture: change temperature between bytes
    wr_bytes(8'h00, 0, 16'h0);
    temp_in = 16'h7D00;
    bus_start; send_byte({4'b1001, PINS, 1'b1}, a);
    recv_byte(1'b1, b0); temp_in = 16'hC9F0; recv_byte(1'b0, b1);
    bus_stop;
    chk("R10 no tearing", {b0, b1}, 16'h7D00);
    rd_word16(w); chk("R10 new value next read", w, 16'hC9F0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule